// File: doc/BRIEF.md
# SPI Slave Select Management Unit

This block is the slave-side front end of an SPI port. It brings the serial clock, data-in and select pins into the system clock domain, shifts bytes MSB first in any of the four clock polarity and phase modes, and decides when the host may load the transmit byte. The select level used inside the unit comes either from the external select pin or from a bit in the control register. Software selection lets a single-slave system run with the pin released for other uses.

The host reaches the unit through a small register port with three addresses: control (0), status (1) and data (2). A data write is refused in two cases. The first is while a byte is being shifted. The second applies with clock phase 0: the select has stayed low since the last completed byte. A refused write sets a sticky write-collision flag. A master bit exists only so that the select level can be checked: when the master bit is set the unit never drives its data-out pin.

Top module: `spi_ss_unit`

## Requirements
- R1: Control bit 2 (select source) chooses the internal select. At 0 the internal select follows `ss_ni` after the two-flop synchronizer. At 1 it equals control bit 3 (software select level), and changes on `ss_ni` have no effect.
- R2: With control bit 2 at 1 and bit 3 at 0, full bytes transfer correctly while `ss_ni` is held high, the same as a pin tied low.
- R3: Received data is taken MSB first, 8 bits per byte. On the eighth sampling edge, status bit 0 (receive full) sets and the byte becomes readable at address 2. A data-register read clears status bit 0.
- R4: The transmit byte is driven on `miso_o` MSB first and is valid on every sampling edge. Control bit 1 (CPOL) sets the idle clock level. Control bit 0 (CPHA) selects sampling on the first edge (0) or the second edge (1).
- R5: While the internal select is high, `miso_oe_o` is 0 and the bit counter returns to zero, so a partial byte is discarded and the next byte is received whole.
- R6: With CPHA=1 the select may stay low across consecutive bytes. A data write between bytes is accepted and is sent as the next byte.
- R7: With CPHA=0, a data write made while the select is low and has not risen since the last completed byte is refused. Status bit 1 (write collision) sets and the transmit byte is unchanged. After the select rises, a write is accepted.
- R8: A data write while a byte is in progress (1 to 7 bits sampled) is refused and sets status bit 1, in either phase.
- R9: Status bit 1 clears only on a status read followed by a data-register access. A data access with no prior status read leaves it set. A refused write that is also the clearing access leaves it set.
- R10: When control bit 4 (master) is 1, `miso_oe_o` stays 0. `mode_fault_o` and status bit 2 are 1 while the internal select is low, and 0 while it is high.
- R11: After reset the control and status registers read 0, `ss_int_o` is 1 and `miso_oe_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sck_i | input | 1 | SPI serial clock from master |
| mosi_i | input | 1 | Serial data from master |
| ss_ni | input | 1 | External select pin, active low |
| miso_o | output | 1 | Serial data to master |
| miso_oe_o | output | 1 | Output enable for miso_o (0 = high impedance) |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | 2 | Register address: 0 control, 1 status, 2 data |
| wdata_i | input | 8 | Register write data |
| rdata_o | output | 8 | Register read data for addr_i |
| ss_int_o | output | 1 | Internal select level |
| rx_full_o | output | 1 | Receive full flag |
| wcol_o | output | 1 | Write collision flag |
| mode_fault_o | output | 1 | Select low while in master mode |

## Verification
The write-collision flag can be set and cleared in the same cycle. This happens when the host has armed the clear with a status read and then issues a data write while a byte is half shifted. The bench shifts three bits, forces a collision, reads status, and then writes again before finishing the byte. The flag must still read 1 afterwards. A later status read followed by a data read, with the select high, must clear it.

// File: rtl/spi_ss_pkg.sv
package spi_ss_pkg;
  typedef struct packed {
    logic master;
    logic sw_sel;
    logic sw_mgmt;
    logic cpol;
    logic cpha;
  } ctrl_t;

  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_STAT = 2'd1;
  localparam logic [1:0] ADDR_DATA = 2'd2;
endpackage

// File: rtl/spi_ss_sync.sv
module spi_ss_sync #(
  parameter int W = 3,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stg
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stg_q[s] <= RST_VAL;
        else         stg_q[s] <= d_i;
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stg_q[s] <= RST_VAL;
        else         stg_q[s] <= stg_q[s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/spi_ss_shift.sv
module spi_ss_shift #(
  parameter int DW = 8,
  localparam int CW = $clog2(DW)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          sck_i,
  input  logic          mosi_i,
  input  logic          active_i,
  input  logic          cpol_i,
  input  logic          cpha_i,
  input  logic [DW-1:0] tx_i,
  output logic          miso_o,
  output logic [DW-1:0] rx_o,
  output logic          byte_done_o,
  output logic          busy_o,
  output logic          hold_o
);
  logic          sck_q, fresh_q;
  logic [CW-1:0] cnt_q;
  logic [DW-1:0] sh_q, rx_sh_q, rx_q;
  logic          rise, fall, lead, trail, smp, shf, last;

  assign rise  = sck_i & ~sck_q;
  assign fall  = ~sck_i & sck_q;
  assign lead  = cpol_i ? fall : rise;
  assign trail = cpol_i ? rise : fall;
  assign smp   = cpha_i ? trail : lead;
  assign shf   = cpha_i ? lead : trail;
  assign last  = (cnt_q == CW'(DW-1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sck_q   <= 1'b0;
      fresh_q <= 1'b1;
      cnt_q   <= '0;
      sh_q    <= '0;
      rx_sh_q <= '0;
      rx_q    <= '0;
    end else begin
      sck_q <= sck_i;
      // select must rise between bytes in phase 0
      if (!active_i)          fresh_q <= 1'b1;
      else if (smp && last)   fresh_q <= 1'b0;
      if (!active_i)          cnt_q <= '0;
      else if (smp)           cnt_q <= last ? '0 : cnt_q + 1'b1;
      if (active_i && smp) begin
        rx_sh_q <= {rx_sh_q[DW-2:0], mosi_i};
        if (last) rx_q <= {rx_sh_q[DW-2:0], mosi_i};
      end
      if (!cpha_i) begin
        if (!active_i || (cnt_q == '0 && fresh_q)) sh_q <= tx_i;
        else if (shf)                              sh_q <= sh_q << 1;
      end else if (active_i && shf) begin
        sh_q <= (cnt_q == '0) ? tx_i : sh_q << 1;
      end
    end
  end

  assign miso_o      = sh_q[DW-1];
  assign rx_o        = rx_q;
  assign byte_done_o = active_i && smp && last;
  assign busy_o      = active_i && (cnt_q != '0);
  assign hold_o      = active_i && !cpha_i && !fresh_q;

  assert_cnt_idle_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active_i |=> (cnt_q == '0));
  assert_done_on_last_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_done_o |=> (cnt_q == '0) && (rx_q[0] == $past(mosi_i)));
endmodule

// File: rtl/spi_ss_regs.sv
module spi_ss_regs
  import spi_ss_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic          rd_en_i,
  input  logic [1:0]    addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  input  logic          busy_i,
  input  logic          hold_i,
  input  logic          byte_done_i,
  input  logic [DW-1:0] rx_i,
  input  logic          mfault_i,
  output ctrl_t         ctrl_o,
  output logic [DW-1:0] tx_o,
  output logic          rx_full_o,
  output logic          wcol_o
);
  localparam int CTW = $bits(ctrl_t);

  ctrl_t         ctrl_q;
  logic [DW-1:0] tx_q;
  logic          rx_full_q, wcol_q, armed_q;
  logic          data_wr, data_rd, data_acc, stat_rd, reject;

  assign data_wr  = wr_en_i && (addr_i == ADDR_DATA);
  assign data_rd  = rd_en_i && (addr_i == ADDR_DATA);
  assign data_acc = data_wr || data_rd;
  assign stat_rd  = rd_en_i && (addr_i == ADDR_STAT);
  assign reject   = data_wr && (busy_i || hold_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q    <= '0;
      tx_q      <= '0;
      rx_full_q <= 1'b0;
      wcol_q    <= 1'b0;
      armed_q   <= 1'b0;
    end else begin
      if (wr_en_i && addr_i == ADDR_CTRL) ctrl_q <= ctrl_t'(wdata_i[CTW-1:0]);
      if (data_wr && !reject)             tx_q <= wdata_i;
      if (byte_done_i)                    rx_full_q <= 1'b1;
      else if (data_rd)                   rx_full_q <= 1'b0;
      if (data_acc)                       armed_q <= 1'b0;
      else if (stat_rd && wcol_q)         armed_q <= 1'b1;
      // a new collision wins over the clearing access
      if (reject)                         wcol_q <= 1'b1;
      else if (data_acc && armed_q)       wcol_q <= 1'b0;
    end
  end

  always_comb begin
    case (addr_i)
      ADDR_CTRL: rdata_o = DW'(ctrl_q);
      ADDR_STAT: rdata_o = DW'({mfault_i, wcol_q, rx_full_q});
      ADDR_DATA: rdata_o = rx_i;
      default:   rdata_o = '0;
    endcase
  end

  assign ctrl_o    = ctrl_q;
  assign tx_o      = tx_q;
  assign rx_full_o = rx_full_q;
  assign wcol_o    = wcol_q;

  assert_busy_wcol_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_wr && busy_i) |=> wcol_q);
  assert_tx_kept_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_wr && hold_i) |=> $stable(tx_q) && wcol_q);
  assert_rx_full_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_done_i |=> rx_full_q);
  assert_no_blind_clear_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wcol_q && !armed_q) |=> wcol_q);
endmodule

// File: rtl/spi_ss_unit.sv
module spi_ss_unit
  import spi_ss_pkg::*;
#(
  parameter int DW = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          sck_i,
  input  logic          mosi_i,
  input  logic          ss_ni,
  output logic          miso_o,
  output logic          miso_oe_o,
  input  logic          wr_en_i,
  input  logic          rd_en_i,
  input  logic [1:0]    addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic          ss_int_o,
  output logic          rx_full_o,
  output logic          wcol_o,
  output logic          mode_fault_o
);
  ctrl_t         ctrl;
  logic [2:0]    pins_s;
  logic          ss_s, sck_s, mosi_s, sel_int, active, mfault_q;
  logic          byte_done, busy, hold;
  logic [DW-1:0] tx, rx;

  spi_ss_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk_i, .rst_ni, .d_i({ss_ni, sck_i, mosi_i}), .q_o(pins_s)
  );
  assign {ss_s, sck_s, mosi_s} = pins_s;

  assign sel_int = ctrl.sw_mgmt ? ctrl.sw_sel : ss_s;
  assign active  = !ctrl.master && !sel_int;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) mfault_q <= 1'b0;
    else         mfault_q <= ctrl.master && !sel_int;

  spi_ss_shift #(.DW(DW)) u_shift (
    .clk_i, .rst_ni, .sck_i(sck_s), .mosi_i(mosi_s), .active_i(active),
    .cpol_i(ctrl.cpol), .cpha_i(ctrl.cpha), .tx_i(tx), .miso_o,
    .rx_o(rx), .byte_done_o(byte_done), .busy_o(busy), .hold_o(hold)
  );

  spi_ss_regs #(.DW(DW)) u_regs (
    .clk_i, .rst_ni, .wr_en_i, .rd_en_i, .addr_i, .wdata_i, .rdata_o,
    .busy_i(busy), .hold_i(hold), .byte_done_i(byte_done), .rx_i(rx),
    .mfault_i(mfault_q), .ctrl_o(ctrl), .tx_o(tx), .rx_full_o, .wcol_o
  );

  assign miso_oe_o    = active;
  assign ss_int_o     = sel_int;
  assign mode_fault_o = mfault_q;

  assert_pin_ignored_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl.sw_mgmt && $stable(ctrl)) |-> $stable(ss_int_o));
  assert_oe_deselect_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ss_int_o |-> !miso_oe_o);
  assert_mfault_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl.master && !ss_int_o) |=> mode_fault_o && !miso_oe_o);
endmodule

// File: tb/sim_spi_ss_unit.sv
module sim_spi_ss_unit;
  localparam int H = 8;
  // {cpol, cpha, tx byte, master byte}
  localparam logic [17:0] VEC [6] = '{
    {1'b0, 1'b0, 8'hA5, 8'h3C},
    {1'b0, 1'b1, 8'h81, 8'h7E},
    {1'b1, 1'b0, 8'h5A, 8'hC3},
    {1'b1, 1'b1, 8'hF0, 8'h0F},
    {1'b0, 1'b0, 8'h01, 8'h80},
    {1'b1, 1'b1, 8'hB6, 8'h49}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic sck = 1'b0, mosi = 1'b0, ss_n = 1'b1;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = 8'h00;
  logic miso, miso_oe, ss_int, rx_full, wcol, mfault;
  logic [7:0] rdata;
  int n_chk = 0, n_bad = 0;
  logic done = 1'b0;

  always #5 clk = ~clk;

  spi_ss_unit u0 (
    .clk_i(clk), .rst_ni(rst_n), .sck_i(sck), .mosi_i(mosi), .ss_ni(ss_n),
    .miso_o(miso), .miso_oe_o(miso_oe), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .ss_int_o(ss_int),
    .rx_full_o(rx_full), .wcol_o(wcol), .mode_fault_o(mfault)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic reg_wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic reg_rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); rd_en = 1'b1; addr = a; #1 d = rdata;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic peek(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; #1 d = rdata;
  endtask

  task automatic xfer(input logic cpol, input logic cpha, input logic [7:0] mo,
                      input int nbits, output logic [7:0] got);
    got = 8'h00;
    for (int i = 0; i < nbits; i++) begin
      if (!cpha) begin
        mosi = mo[7-i]; idle(H);
        got = {got[6:0], miso}; sck = ~cpol; idle(H);
        sck = cpol;
      end else begin
        sck = ~cpol; mosi = mo[7-i]; idle(H);
        got = {got[6:0], miso}; sck = cpol; idle(H);
      end
    end
    idle(H);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog act=hung exp=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] d, got;
    idle(3); rst_n = 1'b1; idle(2);

    // R11 reset state
    peek(2'd0, d); check("R11 ctrl", d, 8'h00);
    peek(2'd1, d); check("R11 status", d, 8'h00);
    check("R11 ss_int", {7'b0, ss_int}, 8'h01);
    check("R11 oe", {7'b0, miso_oe}, 8'h00);

    // R1 select source
    ss_n = 1'b0; idle(4); check("R1 pin low", {7'b0, ss_int}, 8'h00);
    check("R5 oe selected", {7'b0, miso_oe}, 8'h01);
    ss_n = 1'b1; idle(4); check("R1 pin high", {7'b0, ss_int}, 8'h01);
    check("R5 oe deselected", {7'b0, miso_oe}, 8'h00);
    reg_wr(2'd0, 8'h0C); ss_n = 1'b0; idle(4);
    check("R1 sw high pin low", {7'b0, ss_int}, 8'h01);
    reg_wr(2'd0, 8'h04); ss_n = 1'b1; idle(4);
    check("R1 sw low pin high", {7'b0, ss_int}, 8'h00);
    reg_wr(2'd0, 8'h00); idle(4);

    // R4/R3 vector walk over the four modes, pin select
    for (int v = 0; v < 6; v++) begin
      logic cp, ch; logic [7:0] tx, mo;
      {cp, ch, tx, mo} = VEC[v];
      sck = cp; idle(4);
      reg_wr(2'd0, {6'b0, cp, ch});
      reg_wr(2'd2, tx);
      ss_n = 1'b0; idle(H);
      xfer(cp, ch, mo, 8, got);
      ss_n = 1'b1; idle(4);
      check($sformatf("R4 miso v%0d", v), got, tx);
      peek(2'd1, d); check($sformatf("R3 rx_full set v%0d", v), d & 8'h01, 8'h01);
      reg_rd(2'd2, d); check($sformatf("R3 rx byte v%0d", v), d, mo);
      peek(2'd1, d); check($sformatf("R3 rx_full clr v%0d", v), d & 8'h01, 8'h00);
    end

    // R2 software select low, pin held high, CPHA=1
    sck = 1'b0; idle(4);
    reg_wr(2'd0, 8'h05); ss_n = 1'b1;
    reg_wr(2'd2, 8'hA7); idle(H);
    xfer(1'b0, 1'b1, 8'h5E, 8, got);
    check("R2 miso", got, 8'hA7);
    reg_rd(2'd2, d); check("R2 rx", d, 8'h5E);

    // R6 back-to-back with write between bytes
    reg_wr(2'd2, 8'h19);
    xfer(1'b0, 1'b1, 8'h33, 8, got);
    check("R6 miso", got, 8'h19);
    reg_rd(2'd2, d); check("R6 rx", d, 8'h33);
    peek(2'd1, d); check("R6 no wcol", d & 8'h02, 8'h00);

    // R8 write mid-byte
    xfer(1'b0, 1'b1, 8'hE2, 3, got);
    reg_wr(2'd2, 8'hFF);
    peek(2'd1, d); check("R8 wcol", d & 8'h02, 8'h02);
    // R5 deselect drops partial byte
    reg_wr(2'd0, 8'h0D); idle(2);
    check("R5 oe off", {7'b0, miso_oe}, 8'h00);
    reg_wr(2'd0, 8'h05); idle(H);
    xfer(1'b0, 1'b1, 8'h6B, 8, got);
    check("R8 tx kept", got, 8'h19);
    reg_rd(2'd2, d); check("R5 rx after partial", d, 8'h6B);

    // R9 clearing sequence (data read above had no status read first)
    peek(2'd1, d); check("R9 blind access keeps", d & 8'h02, 8'h02);
    reg_rd(2'd1, d); reg_rd(2'd2, d);
    peek(2'd1, d); check("R9 cleared", d & 8'h02, 8'h00);
    // R9 collision on the clearing access
    xfer(1'b0, 1'b1, 8'h00, 3, got);
    reg_wr(2'd2, 8'h11);
    reg_rd(2'd1, d);
    reg_wr(2'd2, 8'h22);
    peek(2'd1, d); check("R9 set wins", d & 8'h02, 8'h02);
    reg_wr(2'd0, 8'h0D); idle(2);
    reg_rd(2'd1, d); reg_rd(2'd2, d);
    peek(2'd1, d); check("R9 cleared again", d & 8'h02, 8'h00);

    // R7 CPHA=0 needs select rise between bytes
    reg_wr(2'd0, 8'h0C); reg_wr(2'd2, 8'h6D);
    reg_wr(2'd0, 8'h04); idle(H);
    xfer(1'b0, 1'b0, 8'h81, 8, got);
    check("R7 first byte", got, 8'h6D);
    reg_wr(2'd2, 8'h42);
    peek(2'd1, d); check("R7 wcol", d & 8'h02, 8'h02);
    reg_rd(2'd1, d); reg_rd(2'd2, d);
    reg_wr(2'd0, 8'h0C); idle(2); reg_wr(2'd0, 8'h04); idle(H);
    xfer(1'b0, 1'b0, 8'h18, 8, got);
    check("R7 tx unchanged", got, 8'h6D);
    reg_wr(2'd0, 8'h0C); reg_wr(2'd2, 8'h42);
    reg_wr(2'd0, 8'h04); idle(H);
    xfer(1'b0, 1'b0, 8'h24, 8, got);
    check("R7 accepted after rise", got, 8'h42);
    peek(2'd1, d); check("R7 no wcol", d & 8'h02, 8'h00);

    // R10 master select check
    reg_wr(2'd0, 8'h14); idle(3);
    check("R10 fault", {7'b0, mfault}, 8'h01);
    check("R10 oe", {7'b0, miso_oe}, 8'h00);
    peek(2'd1, d); check("R10 status", d & 8'h04, 8'h04);
    reg_wr(2'd0, 8'h1C); idle(3);
    check("R10 no fault", {7'b0, mfault}, 8'h00);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule